// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block is the part of a processor's control that decides, at every instruction boundary, whether to leave the running program for an interrupt handler. When the interrupt request is high, the status word allows interrupts and the fetch unit signals a boundary, the sequencer takes over. It masks further interrupts and hands the return address and the old status word to the save logic. It then acknowledges the request and takes a vector from the device on the I/O data lines. The vector is an address into a table in memory. The table entry gives the handler's start address and its execution priority.

The entry takes two reads from memory. The word at the vector is the handler address. The word after it carries the new priority in its low bits. In the final cycle the sequencer loads the program counter and writes a status word with the new priority and the interrupt-enable bit set again, so a higher-priority device can preempt the handler. While the entry runs, a busy output holds off instruction fetch.

Top module: `vint_entry_seq`

## Requirements
- R1: After reset, acknowledge, busy, save strobe, memory read, PC load and status load outputs are all low.
- R2: An entry begins only in a cycle with the boundary strobe high, the interrupt request high and status bit 3 (interrupt enable) set. With any of the three low, no output of the sequence is asserted.
- R3: In the cycle after the entry begins, the status load strobe is high and the loaded value equals the current status word with bit 3 cleared and all other bits unchanged.
- R4: In the following cycle the save strobe is high, and the saved PC and saved status word are the values present in the cycle the entry began, with bit 3 still set in the saved status.
- R5: Acknowledge is then high for exactly ACK_HOLD consecutive cycles (default 2). The vector is taken from the I/O data lines in the last of those cycles. Acknowledge is low before the first memory read.
- R6: Two memory reads follow in consecutive cycles, the first at the vector (zero-extended) and the second at the vector plus one, without wrapping at the vector width. Read data is taken one cycle after each address.
- R7: In the next cycle the PC load strobe carries the word read at the vector. The status load carries the current status word with bits 2..0 replaced by bits 2..0 of the word read at vector plus one, and bit 3 set.
- R8: Busy is high combinationally in the cycle the entry begins and stays high through the load cycle, 6 + ACK_HOLD cycles in all. It is low in the cycle after the load unless a new entry begins there.
- R9: Boundary and interrupt inputs have no effect while an entry is in progress. Once the handler state is loaded, a new request enters again and saves the handler's PC and status, which allows nesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_bnd_i | input | 1 | Instruction boundary strobe |
| int_i | input | 1 | Interrupt request from the controller hub |
| ack_o | output | 1 | Interrupt acknowledge to the hub |
| io_data_i | input | VEC_W | I/O data lines carrying the device vector |
| mem_rd_o | output | 1 | Memory read enable |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after the address |
| pc_i | input | ADDR_W | Address of the next instruction |
| psr_i | input | PSR_W | Current status word |
| save_o | output | 1 | Save strobe for return state |
| save_pc_o | output | ADDR_W | PC to save |
| save_psr_o | output | PSR_W | Status word to save |
| pc_load_o | output | 1 | PC load strobe |
| pc_load_val_o | output | ADDR_W | Handler start address |
| psr_load_o | output | 1 | Status word load strobe |
| psr_load_val_o | output | PSR_W | Status word to load |
| busy_o | output | 1 | Entry in progress, stall fetch |

## Verification
The bench targets the vector at the top of its range, where a design that wraps the second address would fetch the priority from address 0. It holds boundary and request high through the whole entry, so a design that samples them outside the idle state would start a second entry. It drives junk on the I/O data lines outside acknowledge, so a design that captures the vector at the wrong cycle reads the junk. It runs back-to-back nested entries, where a design that saved the status after masking would return with interrupts disabled. It also runs a masked request, which a design without the enable gate would take.

// File: rtl/vint_pkg.sv
package vint_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MASK,
      ST_SAVE,
      ST_ACK,
      ST_RD_HND,
      ST_RD_PRI,
      ST_LOAD
   } vint_state_e;

endpackage

// File: rtl/vint_fsm.sv
module vint_fsm
   import vint_pkg::*;
#(
   parameter int ACK_HOLD = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   output vint_state_e state_o,
   output logic        ack_last_o
);

   localparam int CW = (ACK_HOLD > 1) ? $clog2(ACK_HOLD) : 1;

   vint_state_e state_q, state_d;

   if (ACK_HOLD < 1) begin : g_bad_hold
      $error("vint_fsm: ACK_HOLD must be at least 1");
   end

   if (ACK_HOLD == 1) begin : g_ack_one
      assign ack_last_o = (state_q == ST_ACK);
   end else begin : g_ack_cnt
      logic [CW-1:0] cnt_q;
      logic          last;
      assign last = (cnt_q == CW'(ACK_HOLD - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (state_q == ST_ACK && !last) begin
            cnt_q <= cnt_q + CW'(1);
         end else begin
            cnt_q <= '0;
         end
      end
      assign ack_last_o = (state_q == ST_ACK) && last;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start_i) state_d = ST_MASK;
         ST_MASK:   state_d = ST_SAVE;
         ST_SAVE:   state_d = ST_ACK;
         ST_ACK:    if (ack_last_o) state_d = ST_RD_HND;
         ST_RD_HND: state_d = ST_RD_PRI;
         ST_RD_PRI: state_d = ST_LOAD;
         ST_LOAD:   state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

   AST_START_TO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start_i) |=> (state_q == ST_MASK)); // R2
   AST_ACK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACK && ack_last_o) |=> (state_q == ST_RD_HND)); // R5
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && state_q != ST_LOAD) |=> (state_q != ST_IDLE)); // R9

endmodule

// File: rtl/vint_capture.sv
module vint_capture
   import vint_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int PSR_W  = 16,
   parameter int VEC_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  vint_state_e       state_i,
   input  logic              start_i,
   input  logic              ack_last_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [PSR_W-1:0]  psr_i,
   input  logic [VEC_W-1:0]  io_data_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic [ADDR_W-1:0] saved_pc_o,
   output logic [PSR_W-1:0]  saved_psr_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [ADDR_W-1:0] handler_o
);

   logic [ADDR_W-1:0] pc_q, hnd_q, vec_ext;
   logic [PSR_W-1:0]  psr_q;
   logic [VEC_W-1:0]  vec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         psr_q <= '0;
      end else if (start_i) begin
         pc_q  <= pc_i;
         psr_q <= psr_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            vec_q <= '0;
      else if (state_i == ST_ACK && ack_last_i) vec_q <= io_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    hnd_q <= '0;
      else if (state_i == ST_RD_PRI) hnd_q <= mem_rdata_i[ADDR_W-1:0];
   end

   assign vec_ext     = ADDR_W'(vec_q);
   assign mem_addr_o  = (state_i == ST_RD_PRI) ? vec_ext + ADDR_W'(1) : vec_ext;
   assign saved_pc_o  = pc_q;
   assign saved_psr_o = psr_q;
   assign handler_o   = hnd_q;

   AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_RD_PRI) |-> $stable(vec_q)); // R6
   AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_RD_PRI) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1))); // R6

endmodule

// File: rtl/vint_psr_fmt.sv
module vint_psr_fmt #(
   parameter int PSR_W  = 16,
   parameter int PRIO_W = 3
) (
   input  logic [PSR_W-1:0]  psr_i,
   input  logic [PRIO_W-1:0] prio_i,
   output logic [PSR_W-1:0]  masked_o,
   output logic [PSR_W-1:0]  handler_psr_o
);

   localparam int IE_POS = PRIO_W;

   always_comb begin
      masked_o         = psr_i;
      masked_o[IE_POS] = 1'b0;
      handler_psr_o    = psr_i;
      handler_psr_o[IE_POS] = 1'b1;
      for (int i = 0; i < PRIO_W; i++) begin
         handler_psr_o[i] = prio_i[i];
      end
   end

endmodule

// File: rtl/vint_entry_seq.sv
module vint_entry_seq
   import vint_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 16,
   parameter int PSR_W    = 16,
   parameter int PRIO_W   = 3,
   parameter int VEC_W    = 10,
   parameter int ACK_HOLD = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_bnd_i,
   input  logic              int_i,
   output logic              ack_o,
   input  logic [VEC_W-1:0]  io_data_i,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [PSR_W-1:0]  psr_i,
   output logic              save_o,
   output logic [ADDR_W-1:0] save_pc_o,
   output logic [PSR_W-1:0]  save_psr_o,
   output logic              pc_load_o,
   output logic [ADDR_W-1:0] pc_load_val_o,
   output logic              psr_load_o,
   output logic [PSR_W-1:0]  psr_load_val_o,
   output logic              busy_o
);

   localparam int IE_POS = PRIO_W;

   if (PSR_W <= IE_POS) begin : g_bad_psr
      $error("vint_entry_seq: PSR_W too narrow for priority and enable");
   end
   if (DATA_W < ADDR_W || DATA_W < PRIO_W) begin : g_bad_data
      $error("vint_entry_seq: DATA_W must hold an address and a priority");
   end
   if (ADDR_W <= VEC_W) begin : g_bad_vec
      $error("vint_entry_seq: ADDR_W must exceed VEC_W");
   end

   vint_state_e       state;
   logic              ack_last, start;
   logic [ADDR_W-1:0] handler;
   logic [PSR_W-1:0]  masked_psr, handler_psr;

   assign start = (state == ST_IDLE) && instr_bnd_i && int_i && psr_i[IE_POS];

   vint_fsm #(.ACK_HOLD(ACK_HOLD)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .state_o    (state),
      .ack_last_o (ack_last)
   );

   vint_capture #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSR_W(PSR_W), .VEC_W(VEC_W)
   ) u_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_i     (state),
      .start_i     (start),
      .ack_last_i  (ack_last),
      .pc_i        (pc_i),
      .psr_i       (psr_i),
      .io_data_i   (io_data_i),
      .mem_rdata_i (mem_rdata_i),
      .saved_pc_o  (save_pc_o),
      .saved_psr_o (save_psr_o),
      .mem_addr_o  (mem_addr_o),
      .handler_o   (handler)
   );

   vint_psr_fmt #(.PSR_W(PSR_W), .PRIO_W(PRIO_W)) u_psr_fmt (
      .psr_i         (psr_i),
      .prio_i        (mem_rdata_i[PRIO_W-1:0]),
      .masked_o      (masked_psr),
      .handler_psr_o (handler_psr)
   );

   assign busy_o         = (state != ST_IDLE) || start;
   assign ack_o          = (state == ST_ACK);
   assign save_o         = (state == ST_SAVE);
   assign mem_rd_o       = (state == ST_RD_HND) || (state == ST_RD_PRI);
   assign pc_load_o      = (state == ST_LOAD);
   assign pc_load_val_o  = handler;
   assign psr_load_o     = (state == ST_MASK) || (state == ST_LOAD);
   assign psr_load_val_o = (state == ST_LOAD) ? handler_psr : masked_psr;

   AST_ACK_QUIET_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> !mem_rd_o); // R5
   AST_SAVE_AFTER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      save_o |-> ($past(psr_load_o) && !$past(psr_load_val_o[IE_POS]))); // R4
   AST_MASK_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      (psr_load_o && !pc_load_o) |-> !psr_load_val_o[IE_POS]); // R3
   AST_ENTRY_SETS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |-> (psr_load_o && psr_load_val_o[IE_POS] && $past(mem_rd_o))); // R7
   AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o || mem_rd_o || save_o || pc_load_o) |-> busy_o); // R8
   AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (instr_bnd_i && int_i && psr_i[IE_POS])); // R2

endmodule

// File: tb/vint_entry_seq_bench.sv
`timescale 1ns/1ps
module vint_entry_seq_bench;

   localparam int AW = 16, DW = 16, PW = 16, VW = 10, HOLD = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bnd = 1'b0, intr = 1'b0;
   logic          ack, mem_rd, save, pc_ld, psr_ld, busy;
   logic [VW-1:0] io_data, dev_vec = '0;
   logic [AW-1:0] mem_addr, save_pc, pc_ld_val;
   logic [DW-1:0] mem_rdata;
   logic [PW-1:0] save_psr, psr_ld_val;
   logic [AW-1:0] pc_q, force_pc;
   logic [PW-1:0] psr_q, force_psr;
   logic          force_en = 1'b0;
   int            checks = 0, failures = 0;
   bit            done = 1'b0;

   always #2 clk = ~clk;

   vint_entry_seq #(.ADDR_W(AW), .DATA_W(DW), .PSR_W(PW), .PRIO_W(3),
                    .VEC_W(VW), .ACK_HOLD(HOLD)) u_vint_entry_seq (
      .clk(clk), .rst_n(rst_n), .instr_bnd_i(bnd), .int_i(intr), .ack_o(ack),
      .io_data_i(io_data), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
      .mem_rdata_i(mem_rdata), .pc_i(pc_q), .psr_i(psr_q), .save_o(save),
      .save_pc_o(save_pc), .save_psr_o(save_psr), .pc_load_o(pc_ld),
      .pc_load_val_o(pc_ld_val), .psr_load_o(psr_ld),
      .psr_load_val_o(psr_ld_val), .busy_o(busy)
   );

   function automatic logic [15:0] mem_word(input logic [15:0] a);
      logic [31:0] p;
      p = 32'(a) * 32'h9E37;
      return p[15:0] ^ 16'h5A5A;
   endfunction

   // device: vector only while acknowledged, junk otherwise
   assign io_data = ack ? dev_vec : ~dev_vec;

   // memory with one-cycle latency, junk when not reading
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem_word(mem_addr);
      else        mem_rdata <= 16'hDEAD;
   end

   // CPU registers updated by load ports
   always @(posedge clk) begin
      if (!rst_n) begin
         pc_q <= '0; psr_q <= '0;
      end else if (force_en) begin
         pc_q <= force_pc; psr_q <= force_psr;
      end else begin
         if (pc_ld)  pc_q  <= pc_ld_val;
         if (psr_ld) psr_q <= psr_ld_val;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_cpu(input logic [AW-1:0] pc, input logic [PW-1:0] psr);
      @(negedge clk);
      force_pc = pc; force_psr = psr; force_en = 1'b1;
      @(negedge clk);
      force_en = 1'b0;
   endtask

   task automatic quiet_probe(input logic b, input logic i, input string tag);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         bnd = b; intr = i;
         #1;
         chk({tag, " busy"}, busy, 0);
         chk({tag, " ack"},  ack, 0);
         chk({tag, " psr_load"}, psr_ld, 0);
         chk({tag, " mem_rd"}, mem_rd, 0);
      end
      @(negedge clk);
      bnd = 0; intr = 0;
   endtask

   task automatic run_entry(input logic [VW-1:0] vec);
      logic [AW-1:0] pc0, hnd;
      logic [PW-1:0] psr0, exp_psr;
      @(negedge clk);
      pc0 = pc_q; psr0 = psr_q; dev_vec = vec;
      hnd = mem_word(16'(vec));
      exp_psr = (psr0 & ~16'h000F) | 16'h0008 | (mem_word(16'(vec) + 16'd1) & 16'h0007);
      bnd = 1; intr = 1;
      #1 chk("R8 busy at sample", busy, 1);
      @(negedge clk);   // boundary and request stay high: must be ignored (R9)
      chk("R3 mask strobe", psr_ld, 1);
      chk("R3 masked value", psr_ld_val, psr0 & ~16'h0008);
      chk("R9 no pc load during mask", pc_ld, 0);
      @(negedge clk);
      chk("R4 save strobe", save, 1);
      chk("R4 saved pc", save_pc, pc0);
      chk("R4 saved psr", save_psr, psr0);
      chk("R3 ie cleared in cpu", psr_q[3], 0);
      for (int k = 0; k < HOLD; k++) begin
         @(negedge clk);
         chk("R5 ack high", ack, 1);
         chk("R5 no read during ack", mem_rd, 0);
      end
      @(negedge clk);
      chk("R5 ack low before read", ack, 0);
      chk("R6 first read", mem_rd, 1);
      chk("R6 first address", mem_addr, 16'(vec));
      @(negedge clk);
      chk("R6 second read", mem_rd, 1);
      chk("R6 second address", mem_addr, 16'(vec) + 16'd1);
      @(negedge clk);
      chk("R7 pc load strobe", pc_ld, 1);
      chk("R7 handler address", pc_ld_val, hnd);
      chk("R7 psr load strobe", psr_ld, 1);
      chk("R7 handler psr", psr_ld_val, exp_psr);
      chk("R8 busy through load", busy, 1);
      bnd = 0; intr = 0;
      @(negedge clk);
      chk("R8 busy released", busy, 0);
      chk("R9 handler pc in cpu", pc_q, hnd);
      chk("R7 handler psr in cpu", psr_q, exp_psr);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1 ack in reset", ack, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 ack", ack, 0);
      chk("R1 save", save, 0);
      chk("R1 mem_rd", mem_rd, 0);
      chk("R1 pc_load", pc_ld, 0);
      chk("R1 psr_load", psr_ld, 0);

      // R2: each gating input low in turn
      set_cpu(16'h1234, 16'h00F8);
      quiet_probe(1'b1, 1'b0, "R2 no request");
      quiet_probe(1'b0, 1'b1, "R2 no boundary");
      set_cpu(16'h1234, 16'h00F0);
      quiet_probe(1'b1, 1'b1, "R2 enable clear");

      // directed corners: vector 0 and top vector (no wrap)
      set_cpu(16'h0400, 16'hA5A8);
      run_entry('0);
      set_cpu(16'h7FFE, 16'h0008);
      run_entry({VW{1'b1}});
      // R9 nested: second entry saves handler state
      run_entry(10'h155);
      run_entry(10'h2AA);

      for (int n = 0; n < 40; n++) begin
         if (n % 3 != 0) begin
            set_cpu(16'($urandom()), (16'($urandom()) & 16'hFFF7) | 16'h0008);
         end
         run_entry(VW'($urandom()));
      end

      // after the sequence, a masked request is still ignored
      set_cpu(16'h2222, 16'h0005);
      quiet_probe(1'b1, 1'b1, "R2 masked after entries");

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++; failures++;
         $display("FAIL R8 watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule